// File: doc/BRIEF.md
# Interpolating Table Base-2 Logarithm Unit

This unit returns an approximate base-2 logarithm of a normalized positive number written as an exponent `e` and a 23-bit fraction `m`, with a value of 2^e·(1+m). The exponent is passed through as the integer part of the answer. The fractional part is log2(1+m), built as the fraction itself plus a correction. The correction is read from a 65-entry table that is sampled at every 1/64 step of the fraction, and it is linearly interpolated between the two samples around `m`.

The interpolation weight is the next 7 fraction bits. The product (difference × weight) uses no multiplier. Both factors are turned into logarithms with a leading-one search and the same correction table, the two logarithms are added, and a second table-corrected step converts the sum back. A compare of the two neighbouring samples decides whether the resulting term is added or subtracted.

The unit accepts one sample per cycle on a valid-qualified input. It delivers a signed fixed-point result with 16 fraction bits on a valid-qualified output, through a four-register pipeline. Zero, infinities, NaN and negative numbers are not handled.

Top module: `log2_interp_unit`

## Requirements
- R1: A sample taken with `inValid` high at a rising edge appears on `outLog` with `outValid` high right after the fourth rising edge, counting the sampling edge as the first. `outValid` is low in the three cycles before that.
- R2: While `outValid` is low, `outLog` keeps its last value, whatever `inExp` and `inMant` do while `inValid` is low.
- R3: A zero fraction gives exactly `inExp`·2^16.
- R4: A fraction whose 17 low bits are zero, with k being its top 6 bits, gives exactly inExp·2^16 + k·1024 + round((log2(1+k/64) − k/64)·2^16).
- R5: For any exponent and fraction, outLog/2^16 lies within 2^-12 of inExp + log2(1 + inMant/2^23).
- R6: `inExp` is two's complement in the range −128..127. `outLog` is a two's complement number with 9 integer bits and 16 fraction bits, so negative exponents and a result that rounds up to 128 are both exact in format.
- R7: A new sample may be given every cycle. Each result depends only on its own sample and keeps the order of input.
- R8: Reset (synchronous, active high) clears `outValid` and `outLog` to zero.
- R9: The R5 bound also holds where the correction falls between the two samples, for fractions above 0.45, where the interpolation term is subtracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample qualifier |
| inExp | input | 8 | Signed exponent e |
| inMant | input | 23 | Fraction m, value inMant/2^23 |
| outValid | output | 1 | Result qualifier |
| outLog | output | 25 | Signed result, 9 integer and 16 fraction bits |

## Verification
The two functions that can fall in the same cycle are the start of one sample in stage one and the result of an earlier sample leaving stage four. With a back-to-back stream, every cycle holds four samples in flight at once. The bench drives such streams with mixed exponents and fractions, and checks each result in its own slot against a real-valued logarithm, to detect any mixing between neighbours. It also surrounds single samples with idle cycles and changing idle inputs, to confirm that only the valid cycles load the output.

// File: rtl/log2_interp_pkg.sv
package log2_interp_pkg;

  localparam int KIND_LOG = 0;
  localparam int KIND_EXP = 1;

  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
  } stage_strobe_t;

  // Correction sample j of a table with 2^idxBits steps, scaled by 2^fracBits.
  // KIND_LOG: log2(1+x) - x      KIND_EXP: 1 + x - 2^x   (both non-negative)
  function automatic int corrEntry(int kind, int idxBits, int fracBits, int j);
    real x;
    real v;
    real scale;
    x = real'(j) / real'(1 << idxBits);
    scale = real'(1 << fracBits);
    if (kind == KIND_LOG) v = $ln(1.0 + x) / $ln(2.0) - x;
    else                  v = 1.0 + x - $exp(x * $ln(2.0));
    return $rtoi(v * scale + 0.5);
  endfunction

endpackage

// File: rtl/log2_corr_rom.sv
module log2_corr_rom
  import log2_interp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 16,
  parameter int KIND   = KIND_LOG,
  parameter int PORTS  = 2,
  parameter int AW     = IDX_W + 1
) (
  input  logic [PORTS-1:0][AW-1:0]     addr,
  output logic [PORTS-1:0][FRAC_W-1:0] data
);

  localparam int DEPTH = (1 << IDX_W) + 1;

  logic [FRAC_W-1:0] tbl [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_entry
    localparam int V = corrEntry(KIND, IDX_W, FRAC_W, j);
    assign tbl[j] = FRAC_W'(V);
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign data[p] = (int'(addr[p]) < DEPTH) ? tbl[addr[p]] : '0;
  end

endmodule

// File: rtl/log2_lead_one.sv
module log2_lead_one #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 16,
  parameter int POS_W  = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]   val,
  output logic [POS_W-1:0]  pos,
  output logic [FRAC_W-1:0] frac
);

  localparam int WIDE_W = IN_W + FRAC_W;

  logic [WIDE_W-1:0] shifted;

  always_comb begin
    pos = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (val[i]) pos = POS_W'(i);
    end
  end

  // move the leading one to bit FRAC_W; the bits below it are the fraction
  assign shifted = WIDE_W'(val) << (FRAC_W - int'(pos));
  assign frac    = shifted[FRAC_W-1:0];

endmodule

// File: rtl/log2_interp_ctrl.sv
module log2_interp_ctrl
  import log2_interp_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stage_strobe_t strb,
  output logic          outValid
);

  logic [STAGES-1:0] validPipe;
  logic [2:0]        sinceRst;

  always_ff @(posedge clk) begin
    if (rst) validPipe <= '0;
    else     validPipe <= {validPipe[STAGES-2:0], inValid};
  end

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  assign strb.ld1 = inValid;
  assign strb.ld2 = validPipe[0];
  assign strb.ld3 = validPipe[1];
  assign strb.ld4 = validPipe[2];
  assign outValid = validPipe[STAGES-1];

  // R1: result qualifier follows the input qualifier by four edges
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd4) |-> (outValid == $past(inValid, 4)));

endmodule

// File: rtl/log2_interp_dp.sv
module log2_interp_dp
  import log2_interp_pkg::*;
#(
  parameter int MANT_W   = 23,
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 16,
  parameter int IDX_W    = 6,
  parameter int INTERP_W = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  stage_strobe_t                 strb,
  input  logic signed [EXP_W-1:0]       inExp,
  input  logic [MANT_W-1:0]             inMant,
  output logic signed [EXP_W+FRAC_W:0]  outLog
);

  localparam int AW     = IDX_W + 1;
  localparam int OUT_W  = EXP_W + 1 + FRAC_W;
  localparam int DPOS_W = $clog2(FRAC_W);
  localparam int NPOS_W = $clog2(INTERP_W);
  localparam int LOGI_W = DPOS_W + 2;
  localparam int LOG_W  = LOGI_W + FRAC_W;
  localparam int SH_W   = FRAC_W + INTERP_W;
  localparam int TERM_W = FRAC_W + 1;
  localparam int PROD_W = FRAC_W + 1 + (1 << LOGI_W);
  localparam int FS_W   = FRAC_W + 3;
  localparam int DROP_W = MANT_W - FRAC_W;

  // ---------------- stage 1: split fraction, read neighbours, compare
  logic [IDX_W-1:0]    idx;
  logic [INTERP_W-1:0] wgt;
  logic [MANT_W:0]     mRoundWide;
  logic [FRAC_W:0]     mRound;
  logic [1:0][AW-1:0]      abAddr;
  logic [1:0][FRAC_W-1:0]  abData;
  logic [FRAC_W-1:0]   corrA, corrB, diff;
  logic                bGeA;

  assign idx        = inMant[MANT_W-1 -: IDX_W];
  assign wgt        = inMant[MANT_W-IDX_W-1 -: INTERP_W];
  assign mRoundWide = (MANT_W+1)'(inMant) + (MANT_W+1)'(1 << (DROP_W - 1));
  assign mRound     = mRoundWide[MANT_W -: (FRAC_W+1)];
  assign abAddr     = {AW'(idx) + AW'(1), AW'(idx)};
  assign corrA      = abData[0];
  assign corrB      = abData[1];
  assign bGeA       = (corrB >= corrA);
  assign diff       = bGeA ? (corrB - corrA) : (corrA - corrB);

  log2_corr_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .KIND(KIND_LOG), .PORTS(2), .AW(AW))
    u_romNeighbours (.addr(abAddr), .data(abData));

  logic signed [EXP_W-1:0] s1Exp;
  logic [FRAC_W:0]         s1M;
  logic [FRAC_W-1:0]       s1A, s1Diff;
  logic                    s1Geq;
  logic [INTERP_W-1:0]     s1Wgt;

  always_ff @(posedge clk) begin
    if (strb.ld1) begin
      s1Exp  <= inExp;
      s1M    <= mRound;
      s1A    <= corrA;
      s1Diff <= diff;
      s1Geq  <= bGeA;
      s1Wgt  <= wgt;
    end
  end

  // ---------------- stage 2: logarithms of both factors, summed
  logic [DPOS_W-1:0]      dPos;
  logic [NPOS_W-1:0]      nPos;
  logic [FRAC_W-1:0]      dFrac, nFrac;
  logic [1:0][AW-1:0]     lgAddr;
  logic [1:0][FRAC_W-1:0] lgData;
  logic [LOG_W-1:0]       logSum;
  logic                   termZero;

  log2_lead_one #(.IN_W(FRAC_W), .FRAC_W(FRAC_W), .POS_W(DPOS_W))
    u_lodDiff (.val(s1Diff), .pos(dPos), .frac(dFrac));

  log2_lead_one #(.IN_W(INTERP_W), .FRAC_W(FRAC_W), .POS_W(NPOS_W))
    u_lodWgt (.val(s1Wgt), .pos(nPos), .frac(nFrac));

  assign lgAddr = {AW'(nFrac[FRAC_W-1 -: IDX_W]), AW'(dFrac[FRAC_W-1 -: IDX_W])};

  log2_corr_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .KIND(KIND_LOG), .PORTS(2), .AW(AW))
    u_romFactors (.addr(lgAddr), .data(lgData));

  assign logSum = (LOG_W'(LOGI_W'(dPos) + LOGI_W'(nPos)) << FRAC_W)
                + LOG_W'(dFrac) + LOG_W'(lgData[0])
                + LOG_W'(nFrac) + LOG_W'(lgData[1]);
  assign termZero = (s1Diff == '0) || (s1Wgt == '0);

  logic signed [EXP_W-1:0] s2Exp;
  logic [FRAC_W:0]         s2M;
  logic [FRAC_W-1:0]       s2A, s2Diff;
  logic                    s2Geq, s2Zero;
  logic [LOG_W-1:0]        s2Log;

  always_ff @(posedge clk) begin
    if (strb.ld2) begin
      s2Exp  <= s1Exp;
      s2M    <= s1M;
      s2A    <= s1A;
      s2Diff <= s1Diff;
      s2Geq  <= s1Geq;
      s2Zero <= termZero;
      s2Log  <= logSum;
    end
  end

  // ---------------- stage 3: table-corrected antilog gives the term
  logic [LOGI_W-1:0]      intPart;
  logic [FRAC_W-1:0]      logFrac;
  logic [0:0][AW-1:0]     exAddr;
  logic [0:0][FRAC_W-1:0] exData;
  logic [FRAC_W:0]        powMant;
  logic [PROD_W-1:0]      prodWide;
  logic [TERM_W-1:0]      term;

  assign intPart = s2Log[LOG_W-1 -: LOGI_W];
  assign logFrac = s2Log[FRAC_W-1:0];
  assign exAddr  = AW'(logFrac[FRAC_W-1 -: IDX_W]);

  log2_corr_rom #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .KIND(KIND_EXP), .PORTS(1), .AW(AW))
    u_romPow (.addr(exAddr), .data(exData));

  assign powMant  = {1'b1, logFrac} - {1'b0, exData[0]};
  assign prodWide = PROD_W'(powMant) << intPart;
  assign term     = s2Zero ? '0 : TERM_W'(prodWide >> SH_W);

  logic signed [EXP_W-1:0] s3Exp;
  logic [FRAC_W:0]         s3M;
  logic [FRAC_W-1:0]       s3A, s3Diff;
  logic                    s3Geq;
  logic [TERM_W-1:0]       s3Term;

  always_ff @(posedge clk) begin
    if (strb.ld3) begin
      s3Exp  <= s2Exp;
      s3M    <= s2M;
      s3A    <= s2A;
      s3Diff <= s2Diff;
      s3Geq  <= s2Geq;
      s3Term <= term;
    end
  end

  // ---------------- stage 4: fraction + sample + or - term, add exponent
  logic signed [FS_W-1:0]  fracBase, fracSum;
  logic signed [OUT_W-1:0] resultNext;

  assign fracBase   = $signed(FS_W'(s3M)) + $signed(FS_W'(s3A));
  assign fracSum    = s3Geq ? (fracBase + $signed(FS_W'(s3Term)))
                            : (fracBase - $signed(FS_W'(s3Term)));
  assign resultNext = (OUT_W'(s3Exp) <<< FRAC_W) + OUT_W'(fracSum);

  always_ff @(posedge clk) begin
    if (rst)           outLog <= '0;
    else if (strb.ld4) outLog <= resultNext;
  end

  // R5: the multiplier-free product never exceeds twice the sample difference
  a_r5_term_bound: assert property (@(posedge clk) disable iff (rst)
    strb.ld4 |-> (TERM_W'(s3Term) <= (TERM_W'(s3Diff) << 1)));

endmodule

// File: rtl/log2_interp_unit.sv
module log2_interp_unit
  import log2_interp_pkg::*;
#(
  parameter int MANT_W   = 23,
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 16,
  parameter int IDX_W    = 6,
  parameter int INTERP_W = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic signed [EXP_W-1:0]      inExp,
  input  logic [MANT_W-1:0]            inMant,
  output logic                         outValid,
  output logic signed [EXP_W+FRAC_W:0] outLog
);

  stage_strobe_t strb;

  log2_interp_ctrl #(.STAGES(4)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .strb(strb), .outValid(outValid)
  );

  log2_interp_dp #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W),
    .IDX_W(IDX_W), .INTERP_W(INTERP_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .inExp(inExp), .inMant(inMant), .outLog(outLog)
  );

  // R2: the result only moves when it is being presented
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !$stable(outLog) |-> outValid);

  // R8: reset empties the output
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!outValid && (outLog == '0)));

endmodule

// File: tb/log2_interp_unit_bench.sv
module log2_interp_unit_bench;

  logic               clk = 1'b0;
  logic               rst;
  logic               inValid;
  logic signed [7:0]  inExp;
  logic [22:0]        inMant;
  logic               outValid;
  logic signed [24:0] outLog;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  log2_interp_unit u_log2_interp_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .inExp(inExp),
    .inMant(inMant), .outValid(outValid), .outLog(outLog)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real refLog(input int e, input logic [22:0] m);
    return real'(e) + $ln(1.0 + real'(m) / 8388608.0) / $ln(2.0);
  endfunction

  function automatic longint scaled(input real v);
    return longint'($floor(v * 65536.0 + 0.5));
  endfunction

  task automatic checkNear(input string req, input int e, input logic [22:0] m);
    real r;
    real got;
    r   = refLog(e, m);
    got = real'(longint'(outLog)) / 65536.0;
    check((got - r <= 1.0 / 4096.0) && (r - got <= 1.0 / 4096.0), req,
          longint'(outLog), scaled(r));
  endtask

  function automatic logic [22:0] nextMant();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:9];
  endfunction

  // single sample: drive, then observe four edges later
  task automatic runOne(input int e, input logic [22:0] m);
    @(negedge clk);
    inValid = 1'b1; inExp = 8'(e); inMant = m;
    @(negedge clk);
    inValid = 1'b0; inExp = 8'(e + 37); inMant = ~m;
    repeat (2) @(negedge clk);
    check(!outValid, "R1 early valid", longint'(outValid), 0);
    @(negedge clk);
    check(outValid, "R1 valid at fourth edge", longint'(outValid), 1);
  endtask

  task automatic testReset();
    check(!outValid && outLog == 0, "R8 reset state", longint'(outLog), 0);
  endtask

  task automatic testZeroMant();
    int exps[4] = '{0, 5, -3, 127};
    foreach (exps[i]) begin
      runOne(exps[i], 23'd0);
      check(longint'(outLog) == longint'(exps[i]) * 65536, "R3 zero fraction",
            longint'(outLog), longint'(exps[i]) * 65536);
    end
  endtask

  task automatic testKnots();
    for (int k = 1; k < 64; k += 5) begin
      real x;
      longint exp;
      x   = real'(k) / 64.0;
      exp = 2 * 65536 + k * 1024 + scaled($ln(1.0 + x) / $ln(2.0) - x);
      runOne(2, 23'(k) << 17);
      check(longint'(outLog) == exp, "R4 sample point exact", longint'(outLog), exp);
    end
  endtask

  task automatic testAccuracy();
    for (int i = 0; i < 24; i++) begin
      logic [22:0] m;
      m = nextMant();
      runOne(i - 12, m);
      checkNear("R5 accuracy", i - 12, m);
    end
    runOne(127, 23'h7FFFFF);
    checkNear("R5 R6 top of range", 127, 23'h7FFFFF);
  endtask

  task automatic testNegExp();
    runOne(-128, 23'd0);
    check(longint'(outLog) == -128 * 65536, "R6 most negative exponent",
          longint'(outLog), -128 * 65536);
    runOne(-128, 23'h600001);
    checkNear("R6 negative exponent", -128, 23'h600001);
    runOne(-1, 23'h012345);
    checkNear("R6 exponent -1", -1, 23'h012345);
  endtask

  task automatic testFalling();
    for (int i = 0; i < 16; i++) begin
      logic [22:0] m;
      m = 23'h3A0000 + 23'(nextMant() % 23'h460000);
      runOne(3, m);
      checkNear("R9 descending correction", 3, m);
    end
  endtask

  task automatic testStream();
    int          eq [48];
    logic [22:0] mq [48];
    for (int k = 0; k < 48; k++) begin
      eq[k] = (k * 13) % 200 - 100;
      mq[k] = nextMant();
    end
    for (int k = 0; k < 52; k++) begin
      @(negedge clk);
      if (k >= 4) begin
        check(outValid, "R7 stream valid", longint'(outValid), 1);
        checkNear("R7 stream result", eq[k-4], mq[k-4]);
      end
      if (k < 48) begin
        inValid = 1'b1; inExp = 8'(eq[k]); inMant = mq[k];
      end else begin
        inValid = 1'b0;
      end
    end
  endtask

  task automatic testHold();
    longint held;
    runOne(9, 23'h2AAAAA);
    held = longint'(outLog);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      inExp = 8'(i * 31); inMant = nextMant();
      check(!outValid && longint'(outLog) == held, "R2 idle hold",
            longint'(outLog), held);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; inValid = 1'b0; inExp = '0; inMant = '0;
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    testZeroMant();
    testKnots();
    testAccuracy();
    testNegExp();
    testFalling();
    testStream();
    testHold();
    done = 1;
    finishRun();
  end

endmodule